// File: doc/BRIEF.md
# Ternary Impulse Pattern Sequencer

This block is a slot-accurate digital model of a differential impulse-radio pulse shaper. Each clock cycle stands for one fine time step of the emitted waveform. A trigger starts a fixed burst of 14 slots. During the burst the block drives two single-bit rails, a positive rail and a negative rail. The analog stage downstream takes their difference as the ternary symbol of each slot: +1 when only the positive rail is high, -1 when only the negative rail is high, and 0 when both rails are equal.

The burst is a train of eight pulses of alternating sign with no gaps between them. The pulses at both ends last one slot and the six inner pulses last two slots. Positive and negative slots are equal in number, so the burst has no DC term. A polarity input, captured together with the trigger, swaps the rails for the whole burst so that the block can carry binary phase modulation. An enable input gates everything. A busy flag marks the burst, and the block ignores a trigger while the flag is high.

Top module: `ternary_pulse_seq`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it is released, both rails and busy read 0.
- R2: A trigger sampled high at a rising edge with enable high and busy low starts a burst. From that edge, busy reads 1 for exactly 14 cycles and then reads 0.
- R3: With polarity 0, the rails {positive,negative} in burst slots 0 to 13 are 01,10,10,01,01,10,10,01,01,10,10,01,01,10. Slot 0 is the cycle that directly follows the accepting edge.
- R4: The rails are never both 1, and both rails read 0 whenever busy is 0.
- R5: With polarity 1 at the trigger, every slot carries the R3 pattern with the two rails swapped (positive and negative exchanged).
- R6: Polarity is captured only on the accepting edge. A change of polarity during a burst does not alter that burst.
- R7: A trigger that arrives while busy is 1 is ignored. The running burst keeps its slot order and ends on time, and no new burst follows it.
- R8: While enable is 0, both rails read 0 in the same cycle. At the next edge the burst is abandoned and busy clears, and no trigger is accepted while enable stays 0.
- R9: With the trigger held high, bursts repeat with a period of 15 cycles: the 14 slots, then one cycle with busy 0 and both rails 0.
- R10: A complete burst holds 7 positive slots and 7 negative slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one cycle per time step |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low forces the rails idle and aborts the burst |
| trig | input | 1 | Burst start request |
| pol | input | 1 | Polarity for the next burst (1 = inverted) |
| rail_p | output | 1 | Positive rail |
| rail_n | output | 1 | Negative rail |
| busy | output | 1 | High while a burst is running |

## Verification
The full slot table is checked twice, once with each polarity. The same vectors show both the shape of the pulse train and the rail swap. A burst where the polarity input toggles every slot shows that polarity is captured at the trigger and not followed during the burst. A trigger pulse in the middle of a burst, followed by a look at the cycles after the burst, shows the difference between ignoring the request and queuing it. Holding the trigger high measures the repetition period. Dropping enable partway through a burst shows that the rails are gated in the same cycle and that the burst is abandoned at the next edge.

// File: rtl/tps_pkg.sv
package tps_pkg;

    localparam int unsigned BURST_SLOTS = 14;

    typedef struct packed {
        logic pos;
        logic neg;
    } rail_pair_t;

    // Pulses alternate sign starting negative; the ends are one slot and the
    // inner pulses two slots, so pulse index = (slot + 1) / 2.
    function automatic rail_pair_t slot_rails(input int unsigned slot);
        int unsigned pulse_idx;
        rail_pair_t  r;
        pulse_idx = (slot + 1) / 2;
        r.pos     = pulse_idx[0];
        r.neg     = ~pulse_idx[0];
        return r;
    endfunction

    function automatic rail_pair_t swap_rails(input rail_pair_t r, input logic inv);
        rail_pair_t o;
        o.pos = inv ? r.neg : r.pos;
        o.neg = inv ? r.pos : r.neg;
        return o;
    endfunction

endpackage

// File: rtl/tps_slot_counter.sv
module tps_slot_counter #(
    parameter int unsigned SLOTS = tps_pkg::BURST_SLOTS,
    localparam int unsigned CW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          trig,
    input  logic          pol,
    output logic          active,
    output logic          pol_q,
    output logic [CW-1:0] slot
);
    localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            active <= 1'b0;
            pol_q  <= 1'b0;
            slot   <= '0;
        end else if (!active) begin
            if (trig) begin
                active <= 1'b1;
                pol_q  <= pol;
                slot   <= '0;
            end
        end else if (slot == LAST) begin
            active <= 1'b0;
            slot   <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end
endmodule

// File: rtl/tps_rail_map.sv
module tps_rail_map #(
    parameter int unsigned CW = 4
) (
    input  logic          en,
    input  logic          active,
    input  logic          pol_q,
    input  logic [CW-1:0] slot,
    output tps_pkg::rail_pair_t rails
);
    import tps_pkg::*;

    rail_pair_t base;
    rail_pair_t oriented;

    always_comb begin
        base     = slot_rails(32'(slot));
        oriented = swap_rails(base, pol_q);
        rails    = (en && active) ? oriented : '0;
    end
endmodule

// File: rtl/ternary_pulse_seq.sv
module ternary_pulse_seq #(
    parameter int unsigned SLOTS = tps_pkg::BURST_SLOTS
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic trig,
    input  logic pol,
    output logic rail_p,
    output logic rail_n,
    output logic busy
);
    import tps_pkg::*;

    localparam int unsigned CW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic          active;
    logic          pol_q;
    logic [CW-1:0] slot;
    rail_pair_t    rails;

    tps_slot_counter #(.SLOTS(SLOTS)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .trig   (trig),
        .pol    (pol),
        .active (active),
        .pol_q  (pol_q),
        .slot   (slot)
    );

    tps_rail_map #(.CW(CW)) u_map (
        .en     (en),
        .active (active),
        .pol_q  (pol_q),
        .slot   (slot),
        .rails  (rails)
    );

    assign rail_p = rails.pos;
    assign rail_n = rails.neg;
    assign busy   = active;
endmodule

// File: rtl/ternary_pulse_seq_chk.sv
module ternary_pulse_seq_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic trig,
    input logic rail_p,
    input logic rail_n,
    input logic busy
);
    assert_rails_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(rail_p && rail_n));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!rail_p && !rail_n));

    assert_disable_gates_R8: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!rail_p && !rail_n));

    assert_disable_aborts_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy);

    assert_trigger_starts_R2: assert property (@(posedge clk) disable iff (rst)
        (trig && en && !busy) |=> busy);

    assert_first_slot_live_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && en) |-> (rail_p ^ rail_n));
endmodule

bind ternary_pulse_seq ternary_pulse_seq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .trig   (trig),
    .rail_p (rail_p),
    .rail_n (rail_n),
    .busy   (busy)
);

// File: tb/ternary_pulse_seq_tb.sv
module ternary_pulse_seq_tb;
    logic clk = 1'b0;
    logic rst, en, trig, pol;
    logic rail_p, rail_n, busy;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ternary_pulse_seq u_dut (
        .clk(clk), .rst(rst), .en(en), .trig(trig), .pol(pol),
        .rail_p(rail_p), .rail_n(rail_n), .busy(busy)
    );

    // {pos,neg} per slot for polarity 0
    localparam logic [1:0] EXP [14] = '{
        2'b01, 2'b10, 2'b10, 2'b01, 2'b01, 2'b10, 2'b10,
        2'b01, 2'b01, 2'b10, 2'b10, 2'b01, 2'b01, 2'b10
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {busy, rail_p, rail_n};
        check(act == exp, req, int'(act), int'(exp));
    endtask

    // Trigger a burst with the given polarity and walk the slot table.
    task automatic run_burst(input logic p, input string req);
        @(negedge clk); trig = 1'b1; pol = p;
        @(negedge clk); trig = 1'b0;
        for (int j = 0; j < 14; j++) begin
            check_out(req, {1'b1, p ? {EXP[j][0], EXP[j][1]} : EXP[j]});
            @(negedge clk);
        end
        check_out({req, " end (R2)"}, 3'b000);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int npos, nneg;
        rst = 1'b1; en = 1'b1; trig = 1'b0; pol = 1'b0;
        repeat (3) @(negedge clk);
        check_out("R1 in reset", 3'b000);
        trig = 1'b1;
        @(negedge clk);
        check_out("R1 reset ignores trigger", 3'b000);
        rst = 1'b0; trig = 1'b0;
        @(negedge clk);
        check_out("R1 after release", 3'b000);

        // table walk, both polarities
        run_burst(1'b0, "R3");
        run_burst(1'b1, "R5");

        // R10: balance of positive and negative slots
        npos = 0; nneg = 0;
        @(negedge clk); trig = 1'b1; pol = 1'b0;
        @(negedge clk); trig = 1'b0;
        for (int j = 0; j < 14; j++) begin
            npos += int'(rail_p);
            nneg += int'(rail_n);
            @(negedge clk);
        end
        check(npos == 7, "R10 positive slots", npos, 7);
        check(nneg == 7, "R10 negative slots", nneg, 7);

        // R6: polarity toggles during burst, captured value 1 stays
        @(negedge clk); trig = 1'b1; pol = 1'b1;
        @(negedge clk); trig = 1'b0;
        for (int j = 0; j < 14; j++) begin
            check_out("R6", {1'b1, EXP[j][0], EXP[j][1]});
            pol = ~pol;
            @(negedge clk);
        end
        pol = 1'b0;

        // R7: trigger mid-burst ignored
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        for (int j = 0; j < 14; j++) begin
            check_out("R7", {1'b1, EXP[j]});
            trig = (j == 5);
            @(negedge clk);
        end
        trig = 1'b0;
        for (int j = 0; j < 3; j++) begin
            check_out("R7 no queued burst", 3'b000);
            @(negedge clk);
        end

        // R9: trigger held high, 15-cycle period
        trig = 1'b1;
        @(negedge clk);
        for (int j = 0; j < 14; j++) begin
            check_out("R9 first", {1'b1, EXP[j]});
            @(negedge clk);
        end
        check_out("R9 gap", 3'b000);
        @(negedge clk);
        check_out("R9 restart", {1'b1, EXP[0]});
        trig = 1'b0;
        for (int j = 1; j < 14; j++) @(negedge clk);
        @(negedge clk);
        check_out("R9 drained", 3'b000);

        // R8: enable dropped partway through
        trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        repeat (3) @(negedge clk);
        check_out("R8 running", {1'b1, EXP[3]});
        en = 1'b0;
        #1;
        check(!rail_p && !rail_n, "R8 rails gated", int'({rail_p, rail_n}), 0);
        @(negedge clk);
        check_out("R8 aborted", 3'b000);
        trig = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_out("R8 trigger blocked", 3'b000);
        trig = 1'b0; en = 1'b1;
        @(negedge clk);
        check_out("R8 stays idle", 3'b000);
        run_burst(1'b0, "R8 recovers R3");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule